// File: doc/BRIEF.md
# Stereo Peak Level Meter

This block watches a stream of signed audio samples on several channels and reports, for each channel, how loud the largest sample was during a measurement window. Samples are 26 bits wide: 24-bit full scale plus two headroom bits, so inputs above full scale can be measured up to roughly +12 dB. Each channel keeps a running largest magnitude. When the external update line falls, that magnitude is turned into an 8-bit level code. The code goes into a held output register, and the running value restarts from zero, so each window starts fresh.

The level code has two formats, picked by a strap pin that is sampled only while reset is held. The fine format gives an overrange bit, an idle bit and a 6-bit decibel count. The bar format gives a thermometer pattern that can drive an LED bar directly. Each channel also has an overflow flag, latched on the same update event as its code. Decibel boundaries come from a constant threshold table that is computed when the design is built. Serialization of the codes is handled elsewhere.

Top module: `peak_meter`

## Requirements
- R1: While reset is held and after it is released, every `peak_code` byte and every `ovf_flag` bit is 0 until the first update event.
- R2: The measured magnitude of a sample is its absolute value. The most negative input (-2^25) counts as 2^25-1. The reported peak is the largest magnitude of all valid samples in the window.
- R3: `upd_n_in` passes through a two-flop synchronizer. Its falling edge updates the outputs at the third rising clock edge after the change, and restarts the running peak from zero for the next window. A rising edge changes nothing.
- R4: In fine format (strap 0), a peak above full scale (magnitude > 2^23) gives bit 7 = 1 and bit 6 = 0. Bits 5..0 then hold the count of k in {1,2,3} for which the peak is at least k dB above full scale (0 to 3).
- R5: In fine format, a peak at or below full scale gives bit 7 = 0. Bits 5..0 hold the count of k in 1..60 for which the peak is more than k dB below full scale. Bit 6 is set when the peak is more than 60 dB below full scale, or zero.
- R6: In bar format (strap 1), the code is one of the following:
  - 8'hFF when the peak is above full scale.
  - Otherwise a thermometer 2^n-1, where n counts the points {-3,-6,-10,-20,-30,-40,-60} dB that the peak reaches or exceeds (8'h7F down to 8'h00).
- R7: The format is taken from `bar_strap` during reset only. Changing the strap later has no effect on the codes.
- R8: `ovf_flag[c]` is latched at the update event. It is 1 exactly when the window's peak on channel c exceeded full scale.
- R9: Channels are measured independently. Channel c uses `smp_data[c*26 +: 26]` and reports in `peak_code[c*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap is captured while low |
| bar_strap | input | 1 | Format select: 0 fine, 1 bar graph |
| upd_n_in | input | 1 | Asynchronous update line; falling edge closes the window |
| smp_valid | input | 1 | All channel samples valid this cycle |
| smp_data | input | CH*SW (52) | Signed samples, channel c at bits c*SW upward |
| peak_code | output | CH*8 (16) | Latched level code per channel |
| ovf_flag | output | CH (2) | Latched overrange flag per channel |

## Verification
The bench targets the edges of the encoding:
- A sample of exactly full scale must read 0 dB, not overrange. One count above must read overrange at +0 dB. A design that used >= instead of > would swap these two.
- The most negative input must come out as the largest overrange code. A naive negation would wrap it to a tiny value.
- A silent window must show the idle flag with 60 in the level field, and a peak past +3 dB must stop at 3.
- After a loud window, a quiet window must report quietly. A meter that forgot to clear would repeat the old peak.
- The strap is moved after reset, and the outputs are checked while the update line rises. This catches a live format pin or a meter that reacts to both edges.

// File: rtl/pkm_pkg.sv
package pkm_pkg;

  // Fixed-point gains (Q16): one dB down and one dB up.
  localparam logic [63:0] DB_DOWN_Q16 = 64'd58409;
  localparam logic [63:0] DB_UP_Q16   = 64'd73533;

  // Threshold at `steps` dB below (up=0) or above (up=1) full scale `fs`.
  function automatic logic [63:0] scale_thr(input logic [63:0] fs, input int steps, input bit up);
    logic [63:0] acc;
    acc = fs << 16;
    for (int i = 0; i < steps; i++)
      acc = (acc * (up ? DB_UP_Q16 : DB_DOWN_Q16)) >> 16;
    return (acc + 64'd32768) >> 16;
  endfunction

  // Fine format byte.
  function automatic logic [7:0] fine_code(input logic ovr, input logic idle,
                                           input logic [5:0] lvl);
    return ovr ? {2'b10, lvl} : {1'b0, idle, lvl};
  endfunction

  // Bar format byte from the number of bar points reached.
  function automatic logic [7:0] bar_code(input logic ovr, input logic [3:0] reached);
    logic [8:0] t;
    t = (9'd1 << reached) - 9'd1;
    return ovr ? 8'hFF : t[7:0];
  endfunction

endpackage

// File: rtl/pkm_upd_sync.sv
module pkm_upd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_n_in,
  output logic upd_evt
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= upd_n_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign upd_evt = s3_q & ~s2_q;

  // R3
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> !upd_evt);

endmodule

// File: rtl/pkm_level_enc.sv
module pkm_level_enc #(
  parameter int SW       = 26,
  parameter int FSW      = 24,
  parameter int STEPS_DN = 60,
  parameter int STEPS_UP = 3
) (
  input  logic [SW-1:0] mag,
  input  logic          bar_mode,
  output logic [7:0]    code,
  output logic          ovr
);
  localparam logic [63:0] FS = 64'd1 << (FSW - 1);
  localparam int NBAR = 7;
  localparam int BAR_PTS [NBAR] = '{3, 6, 10, 20, 30, 40, 60};

  logic [63:0]         mag_x;
  logic [STEPS_DN-1:0] below;
  logic [STEPS_UP-1:0] above;
  logic [NBAR-1:0]     reach;
  logic [5:0]          att, up;

  assign mag_x = {{(64-SW){1'b0}}, mag};

  for (genvar k = 1; k <= STEPS_DN; k++) begin : g_dn
    localparam logic [63:0] T = pkm_pkg::scale_thr(FS, k, 1'b0);
    assign below[k-1] = mag_x < T;
  end

  for (genvar k = 1; k <= STEPS_UP; k++) begin : g_up
    localparam logic [63:0] U = pkm_pkg::scale_thr(FS, k, 1'b1);
    assign above[k-1] = mag_x >= U;
  end

  for (genvar b = 0; b < NBAR; b++) begin : g_bar
    assign reach[b] = ~below[BAR_PTS[b]-1];
  end

  always_comb begin
    ovr = mag_x > FS;
    att = 6'($countones(below));
    up  = 6'($countones(above));
    if (bar_mode) code = pkm_pkg::bar_code(ovr, 4'($countones(reach)));
    else          code = pkm_pkg::fine_code(ovr, below[STEPS_DN-1], ovr ? up : att);
  end

endmodule

// File: rtl/pkm_channel.sv
module pkm_channel #(
  parameter int SW  = 26,
  parameter int FSW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bar_mode,
  input  logic          upd_evt,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp,
  output logic [7:0]    code_q,
  output logic          ovf_q
);
  localparam logic [SW-1:0] MAXP = {1'b0, {(SW-1){1'b1}}};

  // Saturating absolute value.
  function automatic logic [SW-1:0] abs_sat(input logic [SW-1:0] v);
    if (!v[SW-1])                     return v;
    else if (v == {1'b1, {(SW-1){1'b0}}}) return MAXP;
    else                              return -v;
  endfunction

  logic [SW-1:0] act_q, smp_mag, peak_nxt;
  logic [7:0]    enc_code;
  logic          enc_ovr;

  assign smp_mag  = abs_sat(smp);
  assign peak_nxt = (smp_valid && smp_mag > act_q) ? smp_mag : act_q;

  pkm_level_enc #(.SW(SW), .FSW(FSW)) u_enc (
    .mag(peak_nxt), .bar_mode(bar_mode), .code(enc_code), .ovr(enc_ovr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      code_q <= '0;
      ovf_q  <= 1'b0;
    end else if (upd_evt) begin
      act_q  <= '0;
      code_q <= enc_code;
      ovf_q  <= enc_ovr;
    end else begin
      act_q  <= peak_nxt;
    end
  end

  // R3
  act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> act_q == '0);
  // R2
  act_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> act_q >= $past(act_q));
  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(code_q) && $stable(ovf_q));
  // R8
  ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !bar_mode) |=> ovf_q == code_q[7]);
  // R5
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !bar_mode) |=> !(code_q[7] && code_q[6]));
  // R6
  bar_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && bar_mode) |=> ((code_q + 8'd1) & code_q) == 8'd0);

endmodule

// File: rtl/peak_meter.sv
module peak_meter #(
  parameter int CH  = 2,
  parameter int SW  = 26,
  parameter int FSW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bar_strap,
  input  logic            upd_n_in,
  input  logic            smp_valid,
  input  logic [CH*SW-1:0] smp_data,
  output logic [CH*8-1:0] peak_code,
  output logic [CH-1:0]   ovf_flag
);
  logic mode_q;
  logic upd_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= bar_strap;
  end

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  pkm_upd_sync u_sync (
    .clk(clk), .rst_n(rst_n), .upd_n_in(upd_n_in), .upd_evt(upd_evt)
  );

  for (genvar c = 0; c < CH; c++) begin : g_ch
    pkm_channel #(.SW(SW), .FSW(FSW)) u_ch (
      .clk(clk), .rst_n(rst_n), .bar_mode(mode_q), .upd_evt(upd_evt),
      .smp_valid(smp_valid), .smp(smp_data[c*SW +: SW]),
      .code_q(peak_code[c*8 +: 8]), .ovf_q(ovf_flag[c])
    );
  end

endmodule

// File: tb/sim_peak_meter.sv
module sim_peak_meter;
  localparam int SW = 26;
  localparam real FSR = 8388608.0;
  localparam longint FSI = 64'd8388608;

  logic clk = 0, rst_n = 0, bar_strap = 0, upd_n_in = 1, smp_valid = 0;
  logic [2*SW-1:0] smp_data = '0;
  logic [15:0] peak_code;
  logic [1:0]  ovf_flag;

  int errors = 0, checks = 0;
  bit done = 0;
  bit exp_bar = 0;
  longint pk0 = 0, pk1 = 0;
  logic [17:0] exp_q[$];
  string tag_q[$];
  logic [17:0] last_exp = '0;

  always #2.5 clk = ~clk;

  peak_meter u0 (.clk(clk), .rst_n(rst_n), .bar_strap(bar_strap), .upd_n_in(upd_n_in),
                 .smp_valid(smp_valid), .smp_data(smp_data),
                 .peak_code(peak_code), .ovf_flag(ovf_flag));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint mag_of(input longint s);
    if (s == -(64'sd1 << 25)) return (64'sd1 << 25) - 1;
    return (s < 0) ? -s : s;
  endfunction

  function automatic longint smp_of(input real db, input bit neg);
    longint m;
    m = longint'(FSR * (10.0 ** (db / 20.0)) + 0.5);
    return neg ? -m : m;
  endfunction

  function automatic logic [7:0] exp_code(input longint m, input bit bar);
    real db;
    int n;
    if (m == 0) return bar ? 8'h00 : 8'h7C;
    db = 20.0 * $log10(real'(m) / FSR);
    if (m > FSI) begin
      if (bar) return 8'hFF;
      n = 0;
      for (int k = 1; k <= 3; k++) if (db >= real'(k)) n++;
      return 8'h80 | 8'(n);
    end
    if (bar) begin
      if (db >= -3.0)  return 8'h7F;
      if (db >= -6.0)  return 8'h3F;
      if (db >= -10.0) return 8'h1F;
      if (db >= -20.0) return 8'h0F;
      if (db >= -30.0) return 8'h07;
      if (db >= -40.0) return 8'h03;
      if (db >= -60.0) return 8'h01;
      return 8'h00;
    end
    n = 0;
    for (int k = 1; k <= 60; k++) if (db < -real'(k)) n++;
    return {1'b0, (db < -60.0), 6'(n)};
  endfunction

  task automatic drive(input longint s0, input longint s1);
    @(negedge clk);
    smp_data  = {SW'(s1), SW'(s0)};
    smp_valid = 1;
    if (mag_of(s0) > pk0) pk0 = mag_of(s0);
    if (mag_of(s1) > pk1) pk1 = mag_of(s1);
    @(negedge clk);
    smp_valid = 0;
    smp_data  = '0;
  endtask

  // Close the window: push expected item, then pulse the update line.
  task automatic close(input string req);
    exp_q.push_back({ (pk1 > FSI), (pk0 > FSI), exp_code(pk1, exp_bar), exp_code(pk0, exp_bar) });
    tag_q.push_back(req);
    pk0 = 0; pk1 = 0;
    repeat (2) @(negedge clk);
    upd_n_in = 0;
    repeat (6) @(negedge clk);
    upd_n_in = 1;
    repeat (5) @(negedge clk);
    // R3: rising edge leaves outputs as latched
    check("R3", "rise code", peak_code, last_exp[15:0]);
    check("R3", "rise ovf", ovf_flag, last_exp[17:16]);
  endtask

  // Monitor: compare at the third rising edge after the fall.
  initial begin
    forever begin
      @(negedge upd_n_in);
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check("R3", "unexpected update", 1, 0);
      end else begin
        last_exp = exp_q.pop_front();
        begin
          string t;
          t = tag_q.pop_front();
          check(t, "ch0 code", peak_code[7:0], last_exp[7:0]);
          check(t, "ch1 code", peak_code[15:8], last_exp[15:8]);
          check("R8", "ovf", ovf_flag, last_exp[17:16]);
        end
      end
    end
  end

  task automatic do_reset(input bit strap);
    rst_n = 0; bar_strap = strap; exp_bar = strap;
    repeat (3) @(negedge clk);
    check("R1", "code in reset", peak_code, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1", "code after reset", peak_code, 0);
    check("R1", "ovf after reset", ovf_flag, 0);
    last_exp = '0;
  endtask

  initial begin
    do_reset(0);
    // Fine format
    drive(smp_of(-0.5, 0), smp_of(-5.5, 1));            close("R5 R9");
    drive(smp_of(2.5, 0), FSI);                         close("R4");
    drive(smp_of(-59.5, 0), smp_of(-61.0, 1));          close("R5 R3");
    drive(-(64'sd1 << 25), FSI + 1);                    close("R2 R4");
    drive(smp_of(-30.5, 1), 0);
    drive(smp_of(-10.5, 0), 0);
    drive(smp_of(-20.5, 1), 0);                         close("R2");
    close("R5 R3");
    drive(smp_of(3.5, 0), smp_of(-12.5, 0));            close("R4");
    // Bar format
    do_reset(1);
    drive(smp_of(-1.5, 0), smp_of(-4.5, 1));            close("R6");
    drive(smp_of(-8.0, 1), smp_of(-15.0, 0));           close("R6");
    drive(smp_of(-25.0, 0), smp_of(-35.0, 1));          close("R6");
    drive(smp_of(-50.0, 0), smp_of(-70.0, 0));          close("R6");
    drive(smp_of(1.0, 1), -(64'sd1 << 25));             close("R6 R2");
    bar_strap = 0;
    drive(smp_of(-1.5, 0), FSI);                        close("R7");
    repeat (5) @(negedge clk);
    check("R3", "queue drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule